// File: doc/BRIEF.md
# I2C Master Command Queue Front-End

This block sits between a register write/read port and the bit-level engine of an I2C master. Software writes command words to a single data address. Each word holds one byte plus three control flags: read, send STOP after this byte, and send a repeated START before it. The words wait in a transmit queue until the engine takes them. Bytes the engine receives are pushed into a receive queue. Software drains that queue by reading the same data address.

Both queue fill levels can be read back. Two programmable thresholds turn the levels into level-sensitive `tx_empty` and `rx_full` conditions, which an interrupt unit elsewhere can use. An enable register asks the engine to start or stop. The engine's acknowledge is reflected in a separate status bit one cycle later. Commands go to the engine only while that status bit is set. An abort from the engine empties both queues, and so does a completed disable.

Top module: `i2c_cmd_frontend`

## Requirements
- R1: A write to address 0x10 is decoded as a command word: bits 7:0 are the byte, bit 8 is the read flag, bit 9 requests a STOP after the byte, bit 10 requests a repeated START before it, and bits above 10 are ignored. For a read command the byte field is dropped and presented to the engine as 0.
- R2: Commands reach `cmd_byte`/`cmd_is_read`/`cmd_stop`/`cmd_restart` in write order. `cmd_valid` is high only while the enable-status bit is 1 and the transmit queue is non-empty. A command is removed on a cycle with `cmd_valid` and `cmd_ready` both high.
- R3: A write to 0x10 while the transmit queue holds DEPTH words is dropped. `tx_over` is then high for exactly the following cycle.
- R4: A read of 0x10 returns the oldest received byte in bits 7:0 (upper bits 0) and removes it. A read of an empty receive queue returns 0 and makes `rx_under` high for the following cycle. A byte offered on `rx_valid` while the receive queue is full is dropped.
- R5: Reads of 0x74 and 0x78 return the transmit and receive fill levels (0 to DEPTH).
- R6: Address 0x3C holds the transmit threshold, keeping the low log2(DEPTH) bits of a write, readable back. `tx_empty` is high while the transmit level is less than or equal to it.
- R7: Address 0x38 holds the receive threshold, stored the same way and readable back. `rx_full` is high while the receive level is greater than it, so a threshold of 0 flags a single byte.
- R8: When `abort_i` is high at a clock edge, both queues are empty after that edge, even if a push happens in the same cycle.
- R9: Bit 0 of address 0x6C is the enable request, driven on `en_req` and readable back. Bit 0 of address 0x9C is the enable status: it copies `en_ack` one cycle late, so it may lag the request.
- R10: At the edge where the enable status falls from 1 to 0, both queues are emptied.
- R11: After reset both levels and both thresholds are 0, enable request and status are 0, `cmd_valid`, `rx_full`, `tx_over` and `rx_under` are low, and `tx_empty` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x10) |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| cmd_valid | output | 1 | A command is available to the engine |
| cmd_ready | input | 1 | Engine takes the current command |
| cmd_byte | output | 8 | Byte to send (0 for reads) |
| cmd_is_read | output | 1 | Command is a read |
| cmd_stop | output | 1 | STOP requested after this byte |
| cmd_restart | output | 1 | Repeated START requested before this byte |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| abort_i | input | 1 | Transfer aborted; empty both queues |
| en_req | output | 1 | Enable request to the engine |
| en_ack | input | 1 | Engine's actual enabled state |
| tx_empty | output | 1 | Transmit level at or below its threshold |
| rx_full | output | 1 | Receive level above its threshold |
| tx_over | output | 1 | One-cycle pulse: a push was dropped |
| rx_under | output | 1 | One-cycle pulse: a pop hit an empty queue |

## Verification
The bench builds the block with DEPTH set to 4, so the thresholds are 2 bits wide. At that size, a handful of writes fill the transmit queue and a handful of engine bytes fill the receive queue. This brings the dropped-push, dropped-receive and threshold-at-maximum cases within reach. It also makes the truncation of threshold writes above 3 observable. The narrow thresholds let every value of the level compare be visited on both sides of the boundary.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;

  // register byte addresses
  localparam logic [7:0] ADR_DATA   = 8'h10;
  localparam logic [7:0] ADR_RX_THR = 8'h38;
  localparam logic [7:0] ADR_TX_THR = 8'h3C;
  localparam logic [7:0] ADR_ENABLE = 8'h6C;
  localparam logic [7:0] ADR_TX_LVL = 8'h74;
  localparam logic [7:0] ADR_RX_LVL = 8'h78;
  localparam logic [7:0] ADR_EN_STS = 8'h9C;

  // command word field positions
  localparam int POS_READ    = 8;
  localparam int POS_STOP    = 9;
  localparam int POS_RESTART = 10;

  typedef struct packed {
    logic              restart;
    logic              stop;
    logic              rd;
    logic [BYTE_W-1:0] data;
  } cmd_t;

  // split a written word into a queued command; reads carry no payload
  function automatic cmd_t decode_cmd(input logic [REG_W-1:0] w);
    cmd_t c;
    c.restart = w[POS_RESTART];
    c.stop    = w[POS_STOP];
    c.rd      = w[POS_READ];
    c.data    = w[POS_READ] ? '0 : w[BYTE_W-1:0];
    return c;
  endfunction

  // transmit side wants refilling while level has sunk to the threshold
  function automatic logic lvl_at_or_below(input int unsigned lvl, input int unsigned thr);
    return lvl <= thr;
  endfunction

  // receive side wants draining once level climbs past the threshold
  function automatic logic lvl_above(input int unsigned lvl, input int unsigned thr);
    return lvl > thr;
  endfunction

endpackage

// File: rtl/icf_sync_fifo.sv
module icf_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [WIDTH-1:0]           push_data,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] count;
  logic             push_ok, pop_ok;

  assign full    = (count == LVL_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];
  assign level   = count;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/icf_enable_ctrl.sv
module icf_enable_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic en_ack,
  output logic en_req,
  output logic en_stat,
  output logic dis_flush
);
  logic req_q, stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (wr_en) req_q <= wr_bit;
      stat_q <= en_ack;
    end
  end

  assign en_req    = req_q;
  assign en_stat   = stat_q;
  // status is about to drop at this edge: empty the queues together with it
  assign dis_flush = stat_q && !en_ack;

endmodule

// File: rtl/icf_thresh.sv
module icf_thresh
  import i2c_cmd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_tx_thr,
  input  logic                     wr_rx_thr,
  input  logic [$clog2(DEPTH)-1:0] wr_val,
  input  logic [$clog2(DEPTH):0]   tx_level,
  input  logic [$clog2(DEPTH):0]   rx_level,
  output logic [$clog2(DEPTH)-1:0] tx_thr,
  output logic [$clog2(DEPTH)-1:0] rx_thr,
  output logic                     tx_empty,
  output logic                     rx_full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr <= '0;
      rx_thr <= '0;
    end else begin
      if (wr_tx_thr) tx_thr <= wr_val;
      if (wr_rx_thr) rx_thr <= wr_val;
    end
  end

  assign tx_empty = lvl_at_or_below(32'(tx_level), 32'(tx_thr));
  assign rx_full  = lvl_above(32'(rx_level), 32'(rx_thr));

endmodule

// File: rtl/i2c_cmd_frontend.sv
module i2c_cmd_frontend
  import i2c_cmd_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_is_read,
  output logic              cmd_stop,
  output logic              cmd_restart,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              abort_i,
  output logic              en_req,
  input  logic              en_ack,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              tx_over,
  output logic              rx_under
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = PTR_W + 1;
  localparam int CMD_W = $bits(cmd_t);

  // address decode
  logic sel_data, sel_rx_thr, sel_tx_thr, sel_en, sel_tx_lvl, sel_rx_lvl, sel_en_sts;
  assign sel_data   = (reg_addr == ADDR_W'(ADR_DATA));
  assign sel_rx_thr = (reg_addr == ADDR_W'(ADR_RX_THR));
  assign sel_tx_thr = (reg_addr == ADDR_W'(ADR_TX_THR));
  assign sel_en     = (reg_addr == ADDR_W'(ADR_ENABLE));
  assign sel_tx_lvl = (reg_addr == ADDR_W'(ADR_TX_LVL));
  assign sel_rx_lvl = (reg_addr == ADDR_W'(ADR_RX_LVL));
  assign sel_en_sts = (reg_addr == ADDR_W'(ADR_EN_STS));

  // named internal events
  logic tx_push, rx_pop, cmd_take, flush, dis_flush, en_stat;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_mt, rx_full_q, rx_mt;
  logic [PTR_W-1:0] tx_thr, rx_thr;
  cmd_t             cmd_in, cmd_head;
  logic [BYTE_W-1:0] rx_head;

  assign tx_push  = reg_wr && sel_data;
  assign rx_pop   = reg_rd && sel_data;
  assign flush    = abort_i || dis_flush;
  assign cmd_in   = decode_cmd(reg_wdata);
  assign cmd_take = cmd_valid && cmd_ready;

  icf_sync_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(tx_push), .push_data(cmd_in),
    .pop(cmd_take), .head(cmd_head),
    .level(tx_lvl), .full(tx_full), .empty(tx_mt)
  );

  icf_sync_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_valid), .push_data(rx_byte),
    .pop(rx_pop), .head(rx_head),
    .level(rx_lvl), .full(rx_full_q), .empty(rx_mt)
  );

  icf_enable_ctrl u_en (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr && sel_en), .wr_bit(reg_wdata[0]),
    .en_ack(en_ack), .en_req(en_req),
    .en_stat(en_stat), .dis_flush(dis_flush)
  );

  icf_thresh #(.DEPTH(DEPTH)) u_thr (
    .clk(clk), .rst_n(rst_n),
    .wr_tx_thr(reg_wr && sel_tx_thr), .wr_rx_thr(reg_wr && sel_rx_thr),
    .wr_val(reg_wdata[PTR_W-1:0]),
    .tx_level(tx_lvl), .rx_level(rx_lvl),
    .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_empty(tx_empty), .rx_full(rx_full)
  );

  // engine-side command presentation
  assign cmd_valid   = en_stat && !tx_mt;
  assign cmd_byte    = cmd_head.data;
  assign cmd_is_read = cmd_head.rd;
  assign cmd_stop    = cmd_head.stop;
  assign cmd_restart = cmd_head.restart;

  // error pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_over  <= 1'b0;
      rx_under <= 1'b0;
    end else begin
      tx_over  <= tx_push && tx_full;
      rx_under <= rx_pop && rx_mt;
    end
  end

  // register read path
  always_comb begin
    reg_rdata = '0;
    if (sel_data && !rx_mt)  reg_rdata = REG_W'(rx_head);
    else if (sel_tx_lvl)     reg_rdata = REG_W'(tx_lvl);
    else if (sel_rx_lvl)     reg_rdata = REG_W'(rx_lvl);
    else if (sel_tx_thr)     reg_rdata = REG_W'(tx_thr);
    else if (sel_rx_thr)     reg_rdata = REG_W'(rx_thr);
    else if (sel_en)         reg_rdata = REG_W'(en_req);
    else if (sel_en_sts)     reg_rdata = REG_W'(en_stat);
  end

  // rx_full_q (receive queue physically full) only gates pushes inside the queue
  logic unused_ok;
  assign unused_ok = rx_full_q;

endmodule

// File: rtl/i2c_cmd_frontend_chk.sv
module i2c_cmd_frontend_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic                   reg_rd,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic                   abort_i,
  input logic                   cmd_valid,
  input logic                   tx_over,
  input logic                   rx_under,
  input logic                   en_stat,
  input logic [$clog2(DEPTH):0] tx_level,
  input logic [$clog2(DEPTH):0] rx_level
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'h10);

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));

  assert_tx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_i |=> int'(tx_level) <= int'($past(tx_level)) + 1);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DATA && int'(tx_level) == DEPTH) |=> tx_over);

  assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DATA && rx_level == '0) |=> rx_under);

  assert_abort_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (tx_level == '0 && rx_level == '0));

  assert_disable_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_stat) |-> (tx_level == '0 && rx_level == '0));

  assert_cmd_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (en_stat && tx_level != '0));

endmodule

bind i2c_cmd_frontend i2c_cmd_frontend_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .abort_i(abort_i), .cmd_valid(cmd_valid), .tx_over(tx_over), .rx_under(rx_under),
  .en_stat(en_stat), .tx_level(tx_lvl), .rx_level(rx_lvl)
);

// File: tb/sim_i2c_cmd_frontend.sv
module sim_i2c_cmd_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int ADDR_W     = 8;

  localparam logic [7:0] A_DATA = 8'h10, A_RXT = 8'h38, A_TXT = 8'h3C, A_EN = 8'h6C,
                         A_TXL = 8'h74, A_RXL = 8'h78, A_STS = 8'h9C;

  // written word -> expected {restart, stop, read, byte}
  localparam int NV = 6;
  localparam logic [31:0] V_IN  [NV] = '{32'h0000_00A5, 32'h0000_01FF, 32'h0000_023C,
                                         32'h0000_047E, 32'h0000_07C3, 32'hFFFF_F811};
  localparam logic [10:0] V_EXP [NV] = '{11'h0A5, 11'h100, 11'h23C, 11'h47E, 11'h700, 11'h011};

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cmd_valid, cmd_ready = 1'b0, cmd_is_read, cmd_stop, cmd_restart;
  logic [7:0] cmd_byte, rx_byte = '0;
  logic rx_valid = 1'b0, abort_i = 1'b0, en_req, en_ack = 1'b0;
  logic tx_empty, rx_full, tx_over, rx_under;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_frontend #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .cmd_is_read(cmd_is_read), .cmd_stop(cmd_stop), .cmd_restart(cmd_restart),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .abort_i(abort_i), .en_req(en_req), .en_ack(en_ack),
    .tx_empty(tx_empty), .rx_full(rx_full), .tx_over(tx_over), .rx_under(rx_under)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic take_cmd();
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(A_TXL, d); check("R11 tx level", d, 0);
    rd(A_RXL, d); check("R11 rx level", d, 0);
    rd(A_STS, d); check("R11 status", d, 0);
    rd(A_TXT, d); check("R11 tx thr", d, 0);
    check("R11 tx_empty", tx_empty, 1);
    check("R11 rx_full", rx_full, 0);
    check("R11 cmd_valid", cmd_valid, 0);
    check("R11 en_req", en_req, 0);
    check("R11 pulses", {tx_over, rx_under}, 0);

    // R2 gating by enable status
    wr(A_DATA, 32'h55);
    rd(A_TXL, d); check("R5 tx level one", d, 1);
    check("R2 no cmd while disabled", cmd_valid, 0);

    // R9 enable request and lagging status
    wr(A_EN, 1);
    check("R9 en_req", en_req, 1);
    rd(A_EN, d); check("R9 enable readback", d, 1);
    rd(A_STS, d); check("R9 status lags", d, 0);
    @(negedge clk); en_ack = 1'b1;
    @(negedge clk);
    rd(A_STS, d); check("R9 status follows ack", d, 1);
    check("R2 cmd_valid when enabled", cmd_valid, 1);
    check("R2 head byte", cmd_byte, 8'h55);
    take_cmd();
    rd(A_TXL, d); check("R2 taken", d, 0);

    // R1 decode table
    for (int i = 0; i < NV; i++) begin
      wr(A_DATA, V_IN[i]);
      check("R2 valid per vector", cmd_valid, 1);
      check("R1 decode", {21'd0, cmd_restart, cmd_stop, cmd_is_read, cmd_byte}, {21'd0, V_EXP[i]});
      take_cmd();
    end

    // R2 ordering
    for (int i = 1; i <= 3; i++) wr(A_DATA, 32'(i));
    for (int i = 1; i <= 3; i++) begin
      check("R2 order", cmd_byte, 8'(i));
      take_cmd();
    end

    // R3 overflow, R6 tx threshold at maximum
    wr(A_TXT, 3);
    for (int i = 0; i < DEPTH; i++) wr(A_DATA, 32'h11 + 32'(i));
    check("R3 no pulse at fill", tx_over, 0);
    check("R6 tx_empty off above thr", tx_empty, 0);
    wr(A_DATA, 32'h99);
    check("R3 tx_over pulse", tx_over, 1);
    @(negedge clk);
    check("R3 pulse one cycle", tx_over, 0);
    rd(A_TXL, d); check("R3 level kept", d, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      check("R3 survivors intact", cmd_byte, 8'h11 + 8'(i));
      take_cmd();
    end

    // R6 threshold truncation and compare
    wr(A_TXT, 6);
    rd(A_TXT, d); check("R6 thr truncated", d, 2);
    wr(A_DATA, 0); wr(A_DATA, 0);
    check("R6 tx_empty at thr", tx_empty, 1);
    wr(A_DATA, 0);
    check("R6 tx_empty above thr", tx_empty, 0);
    for (int i = 0; i < 3; i++) take_cmd();

    // R7 / R4 receive side
    wr(A_RXT, 0);
    check("R7 rx_full empty", rx_full, 0);
    rx_put(8'hA1);
    rd(A_RXL, d); check("R5 rx level", d, 1);
    check("R7 single byte flags", rx_full, 1);
    rd(A_DATA, d); check("R4 pop byte", d, 32'hA1);
    check("R7 cleared", rx_full, 0);
    rd(A_DATA, d); check("R4 empty reads zero", d, 0);
    check("R4 rx_under pulse", rx_under, 1);
    wr(A_RXT, 6);
    rd(A_RXT, d); check("R7 thr truncated", d, 2);
    rx_put(8'hB1); rx_put(8'hB2);
    check("R7 at thr", rx_full, 0);
    rx_put(8'hB3);
    check("R7 above thr", rx_full, 1);
    rx_put(8'hB4); rx_put(8'hB5);
    rd(A_RXL, d); check("R4 full drop level", d, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_DATA, d); check("R4 fifo order", d, 32'hB1 + 32'(i));
    end

    // R8 abort, with a push in the same cycle
    wr(A_DATA, 1); wr(A_DATA, 2); rx_put(8'h01); rx_put(8'h02);
    @(negedge clk); abort_i = 1'b1; reg_addr = A_DATA; reg_wdata = 32'h7; reg_wr = 1'b1;
    @(negedge clk); abort_i = 1'b0; reg_wr = 1'b0;
    rd(A_TXL, d); check("R8 tx flushed", d, 0);
    rd(A_RXL, d); check("R8 rx flushed", d, 0);

    // R10 flush on disable completion
    wr(A_DATA, 1); wr(A_DATA, 2); rx_put(8'h03); rx_put(8'h04);
    wr(A_EN, 0);
    check("R9 request dropped", en_req, 0);
    rd(A_STS, d); check("R10 status still on", d, 1);
    rd(A_TXL, d); check("R10 kept before ack", d, 2);
    @(negedge clk); en_ack = 1'b0;
    @(negedge clk);
    rd(A_STS, d); check("R10 status off", d, 0);
    rd(A_TXL, d); check("R10 tx flushed", d, 0);
    rd(A_RXL, d); check("R10 rx flushed", d, 0);
    check("R2 no cmd after disable", cmd_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule